// File: doc/BRIEF.md
# Four-Channel Paged DMA Controller

This block moves single bytes between peripherals and system memory on behalf of four independent channels. A peripheral raises the request line of its channel. The controller picks one channel at a time and drives that channel's acknowledge for one cycle. The acknowledge enables the peripheral for the transfer in the same way a CPU chip select would. During that cycle the controller also presents the memory address and the transfer direction. After each transfer the channel's current address advances and its remaining count shrinks. When the count runs out, terminal count is flagged. The channel then either masks itself or reloads from its base registers.

Each channel has a 16-bit address generator. Channels 1 to 3 also have a 12-bit page register. Its low ten bits sit above the 16-bit address to form a 26-bit memory address, and its top bit sets the direction of the transfer. Channel 0 has no page register. The CPU programs every register over an 8-bit register port. The 16-bit registers are reached one byte at a time through a shared byte pointer.

Top module: `dma4_page_ctrl`

## Requirements
- R1: After reset, no acknowledge is driven, `xfer_o` is low, all four mask bits read 1, the byte pointer selects the low byte, and every address and count register reads 0.
- R2: Register offset 2c holds channel c's address and offset 2c+1 holds its word count, for c = 0..3. The low byte is accessed first. Every read or write at offsets 0x00-0x07 toggles a shared byte pointer, and any write to offset 0x0D returns the pointer to the low byte. A write loads the base register and the current register together, and a read returns the current register.
- R3: During a transfer, `mem_addr_o[15:0]` equals the channel's current address. The address then increments by one and wraps from 0xFFFF to 0x0000 without changing the upper address bits.
- R4: For channels 1-3, offset 0x10+c carries page bits 7:0 and offset 0x14+c bits 3:0 carry page bits 11:8. During that channel's transfers `mem_addr_o[25:16]` equals page bits 9:0 and `mem_wr_o` equals page bit 11. For channel 0, `mem_addr_o[25:16]` is 0 and `mem_wr_o` equals bit 1 of its mode register.
- R5: A channel loaded with count N performs N+1 transfers before terminal count. `tc_o[c]` is high only in the cycle of the transfer made while the current count is 0, after which the count reads 0xFFFF.
- R6: Offset 0x0C is the mask register, where bit c = 1 masks channel c. When terminal count occurs on a channel whose auto-initialize bit is clear, its mask bit becomes 1 and further requests get no acknowledge.
- R7: Bit 0 of the mode register at offset 0x08+c selects auto-initialize. With it set, terminal count reloads the current address and count from the base registers and leaves the mask bit clear.
- R8: Each grant yields exactly one acknowledge cycle, in which `dack_o` is one-hot and `xfer_o` is high. At least one idle cycle separates transfers. Among unmasked requesting channels, the lowest number wins.
- R9: A request on a masked channel never produces an acknowledge.
- R10: Channel 0 has no page register. Writes to offsets 0x10 and 0x14 are ignored, and both read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_sel_i | input | 1 | Register port select |
| cpu_wr_i | input | 1 | Register write strobe |
| cpu_rd_i | input | 1 | Register read strobe (advances byte pointer) |
| cpu_addr_i | input | 5 | Register offset |
| cpu_wdata_i | input | 8 | Write data |
| cpu_rdata_o | output | 8 | Read data, decoded from offset |
| dreq_i | input | 4 | Per-channel transfer request |
| dack_o | output | 4 | Per-channel acknowledge / peripheral enable |
| xfer_o | output | 1 | Transfer cycle in progress |
| mem_addr_o | output | 26 | Memory address {page, current address} |
| mem_wr_o | output | 1 | 1 = write to memory, 0 = read from memory |
| tc_o | output | 4 | Terminal count, per channel |

## Verification
The transfer path is swept over channels 1-3, each with two address and page patterns. The patterns alternate the direction bit and vary the page value, so a swapped or shifted page field, or a direction taken from the wrong bit, shows up on the address port. One pattern starts at 0xFFFE to show that the wrap stays inside the 16-bit field. Channel 0 runs alone with its mode-held direction to separate it from the paged channels. An auto-initialize run and a self-masking run tell the two terminal-count endings apart. A run with all four requests held, two of them masked, exposes the grant order and the idle gap.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned NUM_CH    = 4;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned PAGE_W    = 12;
  localparam int unsigned PAGE_HI_W = PAGE_W - 8;
  localparam int unsigned REG_AW    = 5;

  localparam logic [REG_AW-1:0] OFS_MODE    = 5'h08;
  localparam logic [REG_AW-1:0] OFS_MASK    = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_CLRPTR  = 5'h0D;
  localparam logic [REG_AW-1:0] OFS_PAGE_LO = 5'h10;
  localparam logic [REG_AW-1:0] OFS_PAGE_HI = 5'h14;

  typedef enum logic {ST_IDLE, ST_XFER} dma_state_e;
endpackage

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic found;

  always_comb begin
    gnt_o = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    AST_GNT_ONEHOT: assert ($onehot0(gnt_o)); // R8
    AST_GNT_SUBSET: assert ((gnt_o & ~req_i) == '0); // R9
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int unsigned WORD_W_P = WORD_W,
  parameter int unsigned PAGE_W_P = PAGE_W,
  parameter bit          HAS_PAGE = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                addr_wr_i,
  input  logic                cnt_wr_i,
  input  logic                hi_byte_i,
  input  logic                mode_wr_i,
  input  logic                page_lo_wr_i,
  input  logic                page_hi_wr_i,
  input  logic [7:0]          wdata_i,
  input  logic                xfer_i,
  output logic [WORD_W_P-1:0] cur_addr_o,
  output logic [WORD_W_P-1:0] cur_cnt_o,
  output logic [PAGE_W_P-1:0] page_o,
  output logic                auto_o,
  output logic                dir0_o,
  output logic                tc_o
);
  logic [WORD_W_P-1:0] base_addr_q, base_cnt_q, cur_addr_q, cur_cnt_q;
  logic [1:0]          mode_q;

  assign tc_o       = xfer_i && (cur_cnt_q == '0);
  assign cur_addr_o = cur_addr_q;
  assign cur_cnt_o  = cur_cnt_q;
  assign auto_o     = mode_q[0];
  assign dir0_o     = mode_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      cur_addr_q  <= '0;
    end else if (addr_wr_i) begin
      if (hi_byte_i) begin
        base_addr_q[WORD_W_P-1:8] <= wdata_i;
        cur_addr_q[WORD_W_P-1:8]  <= wdata_i;
      end else begin
        base_addr_q[7:0] <= wdata_i;
        cur_addr_q[7:0]  <= wdata_i;
      end
    end else if (xfer_i) begin
      cur_addr_q <= (tc_o && mode_q[0]) ? base_addr_q : cur_addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_cnt_q <= '0;
      cur_cnt_q  <= '0;
    end else if (cnt_wr_i) begin
      if (hi_byte_i) begin
        base_cnt_q[WORD_W_P-1:8] <= wdata_i;
        cur_cnt_q[WORD_W_P-1:8]  <= wdata_i;
      end else begin
        base_cnt_q[7:0] <= wdata_i;
        cur_cnt_q[7:0]  <= wdata_i;
      end
    end else if (xfer_i) begin
      cur_cnt_q <= (tc_o && mode_q[0]) ? base_cnt_q : cur_cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= '0;
    else if (mode_wr_i) mode_q <= wdata_i[1:0];
  end

  generate
    if (HAS_PAGE) begin : g_page
      logic [PAGE_W_P-1:0] page_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          page_q <= '0;
        end else begin
          if (page_lo_wr_i) page_q[7:0]          <= wdata_i;
          if (page_hi_wr_i) page_q[PAGE_W_P-1:8] <= wdata_i[PAGE_W_P-9:0];
        end
      end
      assign page_o = page_q;
    end else begin : g_nopage
      logic unused_pg;
      assign unused_pg = page_lo_wr_i ^ page_hi_wr_i;
      assign page_o    = '0;
    end
  endgenerate

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i && !tc_o && !addr_wr_i |=> cur_addr_q == $past(cur_addr_q) + 1'b1); // R3
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i && !tc_o && !cnt_wr_i |=> cur_cnt_q == $past(cur_cnt_q) - 1'b1); // R5
  AST_AUTO_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i && tc_o && mode_q[0] && !addr_wr_i && !cnt_wr_i
    |=> (cur_cnt_q == base_cnt_q) && (cur_addr_q == base_addr_q)); // R7
endmodule

// File: rtl/dma4_page_ctrl.sv
module dma4_page_ctrl
  import dma_pkg::*;
#(
  parameter  int unsigned NUM_CH_P    = NUM_CH,
  parameter  int unsigned WORD_W_P    = WORD_W,
  parameter  int unsigned PAGE_W_P    = PAGE_W,
  localparam int unsigned PAGE_ADDR_W = PAGE_W_P - 2,
  localparam int unsigned MEM_AW      = WORD_W_P + PAGE_ADDR_W,
  localparam int unsigned CH_W        = $clog2(NUM_CH_P)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cpu_sel_i,
  input  logic                cpu_wr_i,
  input  logic                cpu_rd_i,
  input  logic [REG_AW-1:0]   cpu_addr_i,
  input  logic [7:0]          cpu_wdata_i,
  output logic [7:0]          cpu_rdata_o,
  input  logic [NUM_CH_P-1:0] dreq_i,
  output logic [NUM_CH_P-1:0] dack_o,
  output logic                xfer_o,
  output logic [MEM_AW-1:0]   mem_addr_o,
  output logic                mem_wr_o,
  output logic [NUM_CH_P-1:0] tc_o
);
  logic wr_s, rd_s, word_hit, mask_wr, ptr_q;
  logic [NUM_CH_P-1:0] mask_q, req_eff, gnt, gnt_q, tc_v, auto_v, dir0_v;
  logic [WORD_W_P-1:0] cur_addr_v [NUM_CH_P];
  logic [WORD_W_P-1:0] cur_cnt_v  [NUM_CH_P];
  logic [PAGE_W_P-1:0] page_v     [NUM_CH_P];
  dma_state_e state_q;

  assign wr_s     = cpu_sel_i & cpu_wr_i;
  assign rd_s     = cpu_sel_i & cpu_rd_i & ~cpu_wr_i;
  assign word_hit = cpu_addr_i < REG_AW'(2 * NUM_CH_P);
  assign mask_wr  = wr_s && (cpu_addr_i == OFS_MASK);

  // shared byte pointer for the 16-bit registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 ptr_q <= 1'b0;
    else if (wr_s && cpu_addr_i == OFS_CLRPTR)   ptr_q <= 1'b0;
    else if ((wr_s || rd_s) && word_hit)         ptr_q <= ~ptr_q;
  end

  generate
    for (genvar c = 0; c < NUM_CH_P; c++) begin : g_ch
      logic sel_word;
      assign sel_word = word_hit && (cpu_addr_i[CH_W:1] == CH_W'(c));
      dma_chan #(
        .WORD_W_P (WORD_W_P),
        .PAGE_W_P (PAGE_W_P),
        .HAS_PAGE (c != 0)
      ) u_chan (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .addr_wr_i    (wr_s && sel_word && !cpu_addr_i[0]),
        .cnt_wr_i     (wr_s && sel_word &&  cpu_addr_i[0]),
        .hi_byte_i    (ptr_q),
        .mode_wr_i    (wr_s && cpu_addr_i == REG_AW'(OFS_MODE + c)),
        .page_lo_wr_i (wr_s && cpu_addr_i == REG_AW'(OFS_PAGE_LO + c)),
        .page_hi_wr_i (wr_s && cpu_addr_i == REG_AW'(OFS_PAGE_HI + c)),
        .wdata_i      (cpu_wdata_i),
        .xfer_i       (gnt_q[c]),
        .cur_addr_o   (cur_addr_v[c]),
        .cur_cnt_o    (cur_cnt_v[c]),
        .page_o       (page_v[c]),
        .auto_o       (auto_v[c]),
        .dir0_o       (dir0_v[c]),
        .tc_o         (tc_v[c])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '1;
    else if (mask_wr) mask_q <= cpu_wdata_i[NUM_CH_P-1:0];
    else              mask_q <= mask_q | (tc_v & ~auto_v);
  end

  assign req_eff = dreq_i & ~mask_q;

  dma_arb #(.N(NUM_CH_P)) u_arb (
    .req_i (req_eff),
    .gnt_o (gnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      gnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (|req_eff) begin
          state_q <= ST_XFER;
          gnt_q   <= gnt;
        end
        ST_XFER: begin
          state_q <= ST_IDLE;
          gnt_q   <= '0;
        end
        default: begin
          state_q <= ST_IDLE;
          gnt_q   <= '0;
        end
      endcase
    end
  end

  assign dack_o = gnt_q;
  assign xfer_o = (state_q == ST_XFER);
  assign tc_o   = tc_v;

  always_comb begin
    mem_addr_o = '0;
    mem_wr_o   = 1'b0;
    for (int c = 0; c < NUM_CH_P; c++) begin
      if (gnt_q[c]) begin
        mem_addr_o = {page_v[c][PAGE_ADDR_W-1:0], cur_addr_v[c]};
        mem_wr_o   = (c == 0) ? dir0_v[c] : page_v[c][PAGE_W_P-1];
      end
    end
  end

  always_comb begin
    logic [WORD_W_P-1:0] w;
    cpu_rdata_o = '0;
    w = '0;
    for (int c = 0; c < NUM_CH_P; c++) begin
      if (word_hit && cpu_addr_i[CH_W:1] == CH_W'(c)) begin
        w = cpu_addr_i[0] ? cur_cnt_v[c] : cur_addr_v[c];
        cpu_rdata_o = ptr_q ? w[WORD_W_P-1:8] : w[7:0];
      end
      if (cpu_addr_i == REG_AW'(OFS_MODE + c))    cpu_rdata_o = 8'({dir0_v[c], auto_v[c]});
      if (cpu_addr_i == REG_AW'(OFS_PAGE_LO + c)) cpu_rdata_o = page_v[c][7:0];
      if (cpu_addr_i == REG_AW'(OFS_PAGE_HI + c)) cpu_rdata_o = 8'(page_v[c][PAGE_W_P-1:8]);
    end
    if (cpu_addr_i == OFS_MASK) cpu_rdata_o = 8'(mask_q);
  end

  AST_DACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dack_o)); // R8
  AST_XFER_DACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o == (dack_o != '0)); // R8
  AST_XFER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |=> !xfer_o); // R8
  AST_GRANT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> ($past(dreq_i & ~mask_q) & dack_o) != '0); // R9
  AST_TC_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o & ~dack_o) == '0); // R5
  AST_TC_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o && ((tc_o & ~auto_v) != '0) && !mask_wr
    |=> (mask_q & $past(tc_o & ~auto_v)) == $past(tc_o & ~auto_v)); // R6
endmodule

// File: tb/sim_dma4_page_ctrl.sv
module sim_dma4_page_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        sel = 0, wr = 0, rd = 0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic [3:0]  dreq = '0, dack, tc;
  logic        xfer, mwr;
  logic [25:0] maddr;
  int checks = 0, fails = 0;
  bit done = 0;

  dma4_page_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_sel_i(sel), .cpu_wr_i(wr), .cpu_rd_i(rd),
    .cpu_addr_i(addr), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata),
    .dreq_i(dreq), .dack_o(dack), .xfer_o(xfer), .mem_addr_o(maddr),
    .mem_wr_o(mwr), .tc_o(tc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_w(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic cpu_r(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 0; rd = 0;
  endtask

  task automatic wr16(input logic [4:0] a, input logic [15:0] v);
    cpu_w(5'h0D, 8'h00); cpu_w(a, v[7:0]); cpu_w(a, v[15:8]);
  endtask

  task automatic rd16(input logic [4:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    cpu_w(5'h0D, 8'h00); cpu_r(a, lo); cpu_r(a, hi);
    v = {hi, lo};
  endtask

  task automatic one_xfer(input int ch, output logic x, output logic [3:0] dk,
                          output logic [25:0] ma, output logic w, output logic [3:0] t);
    @(negedge clk); dreq = 4'(1 << ch);
    @(negedge clk); x = xfer; dk = dack; ma = maddr; w = mwr; t = tc; dreq = '0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [15:0] v;
    logic x, w;
    logic [3:0] dk, t;
    logic [25:0] ma;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 dack", 32'(dack), 0);
    chk("R1 xfer", 32'(xfer), 0);
    cpu_r(5'h0C, b); chk("R1 mask", 32'(b), 32'h0F);
    rd16(5'h02, v); chk("R1 addr1", 32'(v), 0);
    rd16(5'h07, v); chk("R1 cnt3", 32'(v), 0);

    // R2 byte pointer and base/current load
    wr16(5'h02, 16'h1234);
    rd16(5'h02, v); chk("R2 readback", 32'(v), 32'h1234);
    cpu_w(5'h0D, 0);
    cpu_r(5'h02, b); chk("R2 lo", 32'(b), 32'h34);
    cpu_r(5'h02, b); chk("R2 hi", 32'(b), 32'h12);
    cpu_r(5'h02, b); chk("R2 toggle back", 32'(b), 32'h34);
    cpu_w(5'h0D, 0);
    cpu_r(5'h02, b); chk("R2 clear", 32'(b), 32'h34);

    // R10 channel 0 page ignored
    cpu_w(5'h10, 8'hAB); cpu_w(5'h14, 8'h0F);
    cpu_r(5'h10, b); chk("R10 page lo ch0", 32'(b), 0);
    cpu_r(5'h14, b); chk("R10 page hi ch0", 32'(b), 0);

    // sweep channels 1..3, two patterns each
    for (int ch = 1; ch < 4; ch++) begin
      for (int pat = 0; pat < 2; pat++) begin
        logic [15:0] a;
        logic [11:0] p;
        a = (ch == 3 && pat == 1) ? 16'hFFFE : 16'(16'h0100 * ch + 16'h0040 * pat);
        p = {pat[0], 1'b0, 10'(ch * 37 + pat * 300)};
        wr16(5'(2 * ch), a);
        wr16(5'(2 * ch + 1), 16'd3);
        cpu_w(5'(16 + ch), p[7:0]);
        cpu_w(5'(20 + ch), {4'b0, p[11:8]});
        cpu_r(5'(16 + ch), b); chk("R4 page lo rb", 32'(b), 32'(p[7:0]));
        cpu_w(5'(8 + ch), 8'h00);
        cpu_w(5'h0C, 8'(4'hF & ~(4'b1 << ch)));
        for (int i = 0; i < 4; i++) begin
          one_xfer(ch, x, dk, ma, w, t);
          chk("R8 dack", 32'(dk), 32'(1 << ch));
          chk("R3/R4 addr", 32'(ma), 32'({p[9:0], 16'(a + 16'(i))}));
          chk("R4 dir", 32'(w), 32'(p[11]));
          chk("R5 tc", 32'(t), (i == 3) ? 32'(1 << ch) : 0);
        end
        cpu_r(5'h0C, b); chk("R6 self mask", 32'(b), 32'h0F);
        one_xfer(ch, x, dk, ma, w, t);
        chk("R6 no xfer after tc", 32'(x), 0);
        rd16(5'(2 * ch), v); chk("R3 cur addr", 32'(v), 32'(16'(a + 16'd4)));
        rd16(5'(2 * ch + 1), v); chk("R5 cur cnt", 32'(v), 32'hFFFF);
      end
    end

    // channel 0: no page, direction from mode bit 1
    wr16(5'h00, 16'h0777); wr16(5'h01, 16'd1);
    cpu_w(5'h08, 8'h02);
    cpu_w(5'h0C, 8'h0E);
    for (int i = 0; i < 2; i++) begin
      one_xfer(0, x, dk, ma, w, t);
      chk("R4 ch0 addr", 32'(ma), 32'(16'h0777 + i));
      chk("R4 ch0 dir", 32'(w), 1);
      chk("R5 ch0 tc", 32'(t), (i == 1) ? 1 : 0);
    end

    // R7 auto-initialize on channel 2
    wr16(5'h04, 16'h2000); wr16(5'h05, 16'd1);
    cpu_w(5'h0A, 8'h01);
    cpu_w(5'h0C, 8'h0B);
    for (int i = 0; i < 2; i++) begin
      one_xfer(2, x, dk, ma, w, t);
      chk("R7 addr", 32'(ma[15:0]), 32'(16'h2000 + i));
    end
    chk("R7 tc", 32'(t), 32'h4);
    rd16(5'h04, v); chk("R7 reload addr", 32'(v), 32'h2000);
    rd16(5'h05, v); chk("R7 reload cnt", 32'(v), 1);
    cpu_r(5'h0C, b); chk("R7 stays unmasked", 32'(b), 32'h0B);
    one_xfer(2, x, dk, ma, w, t);
    chk("R7 restart addr", 32'(ma[15:0]), 32'h2000);
    // R9 masked channel 1 ignored
    one_xfer(1, x, dk, ma, w, t);
    chk("R9 masked no xfer", 32'(x), 0);

    // R8 priority with all requests held, ch0 and ch2 masked
    cpu_w(5'h0A, 8'h00);
    wr16(5'h02, 16'h1000); wr16(5'h03, 16'd1);
    wr16(5'h06, 16'h3000); wr16(5'h07, 16'd1);
    cpu_w(5'h0C, 8'h05);
    begin
      logic [3:0] seq [4];
      int n;
      logic prev;
      n = 0; prev = 0;
      @(negedge clk); dreq = 4'hF;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (xfer) begin
          if (prev) chk("R8 idle gap", 1, 0);
          if (n < 4) seq[n] = dack;
          n++;
        end
        prev = xfer;
      end
      dreq = '0;
      chk("R8/R9 total grants", 32'(n), 4);
      chk("R8 order 0", 32'(seq[0]), 2);
      chk("R8 order 1", 32'(seq[1]), 2);
      chk("R8 order 2", 32'(seq[2]), 8);
      chk("R8 order 3", 32'(seq[3]), 8);
    end
    rd16(5'h04, v); chk("R9 ch2 untouched", 32'(v), 32'h2001);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule